// File: doc/BRIEF.md
# Byte-Read Snapshot Statistics Counter

This block counts single-cycle event strobes into a saturating 32-bit register that a host reads through an 8-bit path, one byte per access. The host selects a byte with an index and pulses a read strobe. The selected byte appears on the data output one cycle later. Byte index 0 carries the most significant byte. Reading any byte other than the least significant one freezes the count. The freeze holds until the least significant byte is read, so all bytes of one read come from the same value.

Increment strobes that arrive while the count is frozen are not lost. One pending flag records them. When the read completes, a post-read rule uses this flag. In clear-on-read mode the count restarts at zero, or at one if an increment was pending. In keep-value mode the count is kept, plus one if an increment was pending. A saturated count always follows the clear-on-read rule when its read completes. A narrow mode limits the count to its low 16 bits, so the host reads it with two accesses. An attention pulse marks the moment the top bit of the active width first becomes set.

Top module: `snap_stat_counter`

## Requirements
- R1: While `rst_n` is low at a clock edge, the count, the pending state and the freeze are cleared, and `rd_data_o` and `attn_o` read 0 after that edge.
- R2: With no read strobe, no freeze active and the count below its limit, each cycle with `inc_i` high adds exactly one to the count.
- R3: A read strobe at index k returns, on `rd_data_o` in the following cycle, byte k of the visible count in big-endian order: index 0 is bits 31:24 and index 3 is bits 7:0. The output holds until the next read strobe.
- R4: With `full_width_i` low, the count is limited to 16 bits. Indices 2 and 3 return its upper and lower byte, and indices 0 and 1 return zero.
- R5: A read at any index other than 3 starts a freeze. Until the read of index 3, the count does not change. Repeated reads, including a second read of index 0, keep returning the frozen value.
- R6: With `clr_on_rd_i` high, the count becomes 0 after the cycle in which index 3 is read, or 1 if an increment was attempted during the freeze.
- R7: With `clr_on_rd_i` low and the count below its limit, the count keeps its value after index 3 is read, plus one if an increment was attempted during the freeze.
- R8: Once the count reaches the limit of the active width (all ones), further increments do not change it.
- R9: When index 3 of a saturated count is read, the count becomes 0, or 1 if an increment was attempted during the freeze, whatever `clr_on_rd_i` says. Increments that arrived while saturated before the read began are discarded.
- R10: `attn_o` is high for exactly one cycle: the first cycle in which the top bit of the active width (bit 31, or bit 15 in narrow mode) reads 1 after having read 0.
- R11: An increment in the same cycle as the freeze-starting read, or in the same cycle as the index-3 read, counts as an attempt during the freeze.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| inc_i | input | 1 | Single-cycle event strobe |
| rd_i | input | 1 | Byte read strobe |
| rd_idx_i | input | 2 | Byte index of the read, 0 = most significant |
| full_width_i | input | 1 | 1: 32-bit count; 0: narrow 16-bit count read with two accesses |
| clr_on_rd_i | input | 1 | 1: clear-on-read post-read rule; 0: keep-value rule |
| rd_data_o | output | 8 | Byte returned by the most recent read |
| attn_o | output | 1 | One-cycle pulse when the active top bit becomes set |

## Verification
The embedded assertions check the cycle-level rules on every clock. They check that the count is stable during a freeze and stuck at its limit when saturated. They check single steps when no read is involved, the value range after a completed read in each post-read mode, and that the attention pulse is a single cycle aligned with a set top bit. Only the bench scenarios can show the end-to-end outcomes. These include byte ordering across a whole four-access read, the exact 0/1 or kept/bumped value after a freeze with and without a pending increment, and the saturated-read recovery that discards earlier events. They also include the attention pulse at the 16-bit half point, which takes tens of thousands of increments to reach. A second, narrower instance lets saturation in full-width mode be reached in a practical run.

// File: rtl/snap_stat_pkg.sv
// Package: shared types for the snapshot statistics counter.
// Assumes nothing beyond SystemVerilog 2017 enum support.
package snap_stat_pkg;

    // Action the counter core applies in the cycle a read completes.
    typedef enum logic [1:0] {
        POST_KEEP = 2'd0,   // no completion, or completion with value kept
        POST_ZERO = 2'd1,   // completion, count restarts at zero
        POST_ONE  = 2'd2,   // completion, count restarts at one
        POST_BUMP = 2'd3    // completion, kept value plus one
    } post_act_e;

endpackage

// File: rtl/snap_read_seq.sv
// Module: snap_read_seq
// Tracks the host read sequence. Any read at a non-final byte index starts a
// freeze, and the read of the final (least significant) index completes it.
// Increment attempts made while frozen are folded into one pending flag. At
// completion, the post-read action is chosen from the configuration and the
// saturation state.
// Assumes: rd_i and inc_i are single-cycle strobes sampled on clk.
module snap_read_seq #(
    parameter int NBYTES = 4,
    localparam int IDX_W = $clog2(NBYTES)
) (
    input  logic                        clk,
    input  logic                        rst_n,
    input  logic                        inc_i,
    input  logic                        rd_i,
    input  logic [IDX_W-1:0]            rd_idx_i,
    input  logic                        clr_on_rd_i,
    input  logic                        at_limit_i,
    output logic                        freeze_o,
    output logic                        done_o,
    output snap_stat_pkg::post_act_e    act_o
);
    import snap_stat_pkg::*;

    localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(NBYTES - 1);

    logic hold_q;
    logic pend_q;
    logic last_rd;
    logic start_rd;
    logic pend_eff;
    logic clear_rule;

    // Decode the read strobe into completion and freeze start.
    always_comb begin
        last_rd  = rd_i && (rd_idx_i == LAST_IDX);
        start_rd = rd_i && !last_rd && !hold_q;
        pend_eff = pend_q || inc_i;
    end

    // Choose the post-read action for the completing cycle.
    always_comb begin
        clear_rule = clr_on_rd_i || at_limit_i;
        act_o      = POST_KEEP;
        if (last_rd) begin
            if (clear_rule) begin
                act_o = pend_eff ? POST_ONE : POST_ZERO;
            end else begin
                act_o = pend_eff ? POST_BUMP : POST_KEEP;
            end
        end
    end

    // Freeze flag: set by a non-final read, cleared by the final read.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            hold_q <= 1'b0;
        end else if (last_rd) begin
            hold_q <= 1'b0;
        end else if (start_rd) begin
            hold_q <= 1'b1;
        end
    end

    // Pending flag: records any increment made while frozen.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pend_q <= 1'b0;
        end else if (last_rd) begin
            pend_q <= 1'b0;
        end else if (freeze_o && inc_i) begin
            pend_q <= 1'b1;
        end
    end

    assign freeze_o = hold_q || rd_i;
    assign done_o   = last_rd;

    // R11: an increment in the freeze-starting cycle must be remembered
    a_r11_start_pending: assert property (@(posedge clk) disable iff (!rst_n)
        (start_rd && inc_i) |=> pend_q);

    // R5: pending state is released only by a completed read
    a_r5_pending_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        (pend_q && !last_rd) |=> pend_q);

endmodule

// File: rtl/snap_sat_core.sv
// Module: snap_sat_core
// Holds the count register. It advances by one per accepted increment when not
// frozen and below the active limit, and applies the post-read action chosen
// by the read sequencer in the completing cycle. The limit is all ones over
// the full width, or over the low SHORT_W bits in narrow mode.
// Assumes: SHORT_W < CNT_W; act_i is POST_KEEP unless a read completes.
module snap_sat_core #(
    parameter int CNT_W   = 32,
    parameter int SHORT_W = 16
) (
    input  logic                        clk,
    input  logic                        rst_n,
    input  logic                        inc_i,
    input  logic                        freeze_i,
    input  logic                        done_i,
    input  logic                        full_width_i,
    input  logic                        clr_on_rd_i,
    input  snap_stat_pkg::post_act_e    act_i,
    output logic [CNT_W-1:0]            cnt_o,
    output logic [CNT_W-1:0]            cnt_next_o,
    output logic [CNT_W-1:0]            limit_o,
    output logic                        at_limit_o
);
    import snap_stat_pkg::*;

    localparam logic [CNT_W-1:0] FULL_LIM  = '1;
    localparam logic [CNT_W-1:0] SHORT_LIM = {{(CNT_W-SHORT_W){1'b0}}, {SHORT_W{1'b1}}};
    localparam logic [CNT_W-1:0] ONE       = CNT_W'(1);

    logic [CNT_W-1:0] cnt_q;
    logic [CNT_W-1:0] cnt_d;
    logic             step_ok;

    // Active limit and saturation flag for the selected width.
    always_comb begin
        limit_o    = full_width_i ? FULL_LIM : SHORT_LIM;
        at_limit_o = (cnt_q >= limit_o);
        step_ok    = inc_i && !freeze_i && !at_limit_o;
    end

    // Next count: post-read action wins, otherwise a guarded single step.
    always_comb begin
        unique case (act_i)
            POST_ZERO: cnt_d = '0;
            POST_ONE:  cnt_d = ONE;
            POST_BUMP: cnt_d = cnt_q + ONE;
            default:   cnt_d = step_ok ? (cnt_q + ONE) : cnt_q;
        endcase
    end

    // Count register.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else begin
            cnt_q <= cnt_d;
        end
    end

    assign cnt_o      = cnt_q;
    assign cnt_next_o = cnt_d;

    // R8: a saturated count does not move until a read completes
    a_r8_hold_at_limit: assert property (@(posedge clk) disable iff (!rst_n)
        (at_limit_o && !done_i) |=> $stable(cnt_q));

    // R2: outside any read, the count moves by the increment strobe only
    a_r2_single_step: assert property (@(posedge clk) disable iff (!rst_n)
        (!freeze_i && !at_limit_o) |=> (cnt_q == $past(cnt_q) + CNT_W'($past(inc_i))));

    // R6: clear-on-read leaves zero or one after completion
    a_r6_clear_result: assert property (@(posedge clk) disable iff (!rst_n)
        (done_i && clr_on_rd_i) |=> (cnt_q <= ONE));

    // R7: keep-value completion below the limit moves the count by at most one
    a_r7_keep_result: assert property (@(posedge clk) disable iff (!rst_n)
        (done_i && !clr_on_rd_i && !at_limit_o) |=> ((cnt_q - $past(cnt_q)) <= ONE));

    // R9: a saturated read completion always restarts at zero or one
    a_r9_sat_recover: assert property (@(posedge clk) disable iff (!rst_n)
        (done_i && at_limit_o) |=> (cnt_q <= ONE));

endmodule

// File: rtl/snap_byte_sel.sv
// Module: snap_byte_sel
// Splits the visible count into byte lanes, most significant lane at index 0,
// and registers the lane chosen by the read strobe onto the data output.
// Assumes: NBYTES is a power of two so every index value names a lane.
module snap_byte_sel #(
    parameter int CNT_W  = 32,
    parameter int BYTE_W = 8,
    localparam int NBYTES = CNT_W / BYTE_W,
    localparam int IDX_W  = $clog2(NBYTES)
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                rd_i,
    input  logic [IDX_W-1:0]    rd_idx_i,
    input  logic [CNT_W-1:0]    cnt_i,
    input  logic [CNT_W-1:0]    limit_i,
    output logic [BYTE_W-1:0]   rd_data_o
);
    logic [CNT_W-1:0]  vis;
    logic [BYTE_W-1:0] lane [NBYTES];

    // Bits above the active width read as zero.
    always_comb begin
        vis = cnt_i & limit_i;
    end

    // Big-endian lane map: lane 0 carries the top byte.
    for (genvar b = 0; b < NBYTES; b++) begin : g_lane
        assign lane[b] = vis[BYTE_W*(NBYTES-1-b) +: BYTE_W];
    end

    // Capture the addressed lane on each read strobe.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rd_data_o <= '0;
        end else if (rd_i) begin
            rd_data_o <= lane[rd_idx_i];
        end
    end

    // R3: without a read strobe the returned byte is held
    a_r3_data_held: assert property (@(posedge clk) disable iff (!rst_n)
        !rd_i |=> $stable(rd_data_o));

endmodule

// File: rtl/snap_attn_det.sv
// Module: snap_attn_det
// Raises a one-cycle attention pulse when the top bit of the active width goes
// from 0 in the current count to 1 in the next count.
// Assumes: the width select is steady across the edge being compared.
module snap_attn_det #(
    parameter int CNT_W   = 32,
    parameter int SHORT_W = 16
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                full_width_i,
    input  logic [CNT_W-1:0]    cnt_i,
    input  logic [CNT_W-1:0]    cnt_next_i,
    output logic                attn_o
);
    logic top_now;
    logic top_next;

    // Pick the top bit of the active width for both values.
    always_comb begin
        top_now  = full_width_i ? cnt_i[CNT_W-1]      : cnt_i[SHORT_W-1];
        top_next = full_width_i ? cnt_next_i[CNT_W-1] : cnt_next_i[SHORT_W-1];
    end

    // Register the rising top bit as a pulse aligned with the new count.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            attn_o <= 1'b0;
        end else begin
            attn_o <= !top_now && top_next;
        end
    end

    // R10: the pulse lasts one cycle only
    a_r10_one_cycle: assert property (@(posedge clk) disable iff (!rst_n)
        attn_o |=> !attn_o);

endmodule

// File: rtl/snap_stat_counter.sv
// Module: snap_stat_counter (top)
// Saturating event counter read one byte at a time, most significant byte
// first. A read freezes the count until the least significant byte is read.
// Increments during the freeze are deferred and resolved by the post-read rule.
// Assumes: inc_i and rd_i are single-cycle strobes; CNT_W is a multiple of
// BYTE_W with a power-of-two byte count; SHORT_W < CNT_W.
module snap_stat_counter #(
    parameter int CNT_W   = 32,
    parameter int SHORT_W = 16,
    parameter int BYTE_W  = 8,
    localparam int NBYTES = CNT_W / BYTE_W,
    localparam int IDX_W  = $clog2(NBYTES)
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                inc_i,
    input  logic                rd_i,
    input  logic [IDX_W-1:0]    rd_idx_i,
    input  logic                full_width_i,
    input  logic                clr_on_rd_i,
    output logic [BYTE_W-1:0]   rd_data_o,
    output logic                attn_o
);
    import snap_stat_pkg::*;

    logic             freeze;
    logic             done;
    logic             at_limit;
    post_act_e        act;
    logic [CNT_W-1:0] cnt;
    logic [CNT_W-1:0] cnt_next;
    logic [CNT_W-1:0] limit;

    snap_read_seq #(
        .NBYTES (NBYTES)
    ) u_seq (
        .clk         (clk),
        .rst_n       (rst_n),
        .inc_i       (inc_i),
        .rd_i        (rd_i),
        .rd_idx_i    (rd_idx_i),
        .clr_on_rd_i (clr_on_rd_i),
        .at_limit_i  (at_limit),
        .freeze_o    (freeze),
        .done_o      (done),
        .act_o       (act)
    );

    snap_sat_core #(
        .CNT_W   (CNT_W),
        .SHORT_W (SHORT_W)
    ) u_core (
        .clk          (clk),
        .rst_n        (rst_n),
        .inc_i        (inc_i),
        .freeze_i     (freeze),
        .done_i       (done),
        .full_width_i (full_width_i),
        .clr_on_rd_i  (clr_on_rd_i),
        .act_i        (act),
        .cnt_o        (cnt),
        .cnt_next_o   (cnt_next),
        .limit_o      (limit),
        .at_limit_o   (at_limit)
    );

    snap_byte_sel #(
        .CNT_W  (CNT_W),
        .BYTE_W (BYTE_W)
    ) u_sel (
        .clk       (clk),
        .rst_n     (rst_n),
        .rd_i      (rd_i),
        .rd_idx_i  (rd_idx_i),
        .cnt_i     (cnt),
        .limit_i   (limit),
        .rd_data_o (rd_data_o)
    );

    snap_attn_det #(
        .CNT_W   (CNT_W),
        .SHORT_W (SHORT_W)
    ) u_attn (
        .clk          (clk),
        .rst_n        (rst_n),
        .full_width_i (full_width_i),
        .cnt_i        (cnt),
        .cnt_next_i   (cnt_next),
        .attn_o       (attn_o)
    );

    // R5: while frozen and not completing, the count is stable
    a_r5_frozen: assert property (@(posedge clk) disable iff (!rst_n)
        (freeze && !done) |=> $stable(cnt));

    // R10: attention only accompanies a set top bit of the active width
    a_r10_top_set: assert property (@(posedge clk) disable iff (!rst_n)
        attn_o |-> (full_width_i ? cnt[CNT_W-1] : cnt[SHORT_W-1]));

endmodule

// File: tb/snap_stat_counter_tb.sv
module snap_stat_counter_tb;

    typedef struct {
        longint c;
        bit     h;
        bit     p;
        int     d;
        bit     a;
    } mstate_t;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       inc = 1'b0;
    logic       rd = 1'b0;
    logic [1:0] idx = 2'd0;
    logic       full = 1'b1;
    logic       clr = 1'b0;
    logic [7:0] d_big;
    logic       a_big;
    logic [7:0] d_small;
    logic       a_small;

    int checks = 0;
    int errors = 0;
    mstate_t mb;
    mstate_t ms;

    always #4 clk = ~clk;

    snap_stat_counter u_dut (
        .clk (clk), .rst_n (rst_n), .inc_i (inc), .rd_i (rd), .rd_idx_i (idx),
        .full_width_i (full), .clr_on_rd_i (clr),
        .rd_data_o (d_big), .attn_o (a_big)
    );

    snap_stat_counter #(.CNT_W (16), .SHORT_W (8)) u_dut_small (
        .clk (clk), .rst_n (rst_n), .inc_i (inc), .rd_i (rd), .rd_idx_i (idx[0]),
        .full_width_i (full), .clr_on_rd_i (clr),
        .rd_data_o (d_small), .attn_o (a_small)
    );

    function automatic bit topbit(longint v, int pos);
        return bit'((v >> pos) & 1);
    endfunction

    // Reference model of one clock edge, written from the requirements.
    function automatic void mstep(inout mstate_t s, input bit i_inc, input bit i_rd,
                                  input int i_idx, input bit i_full, input bit i_clr,
                                  input int w, input int sw);
        int     last = w / 8 - 1;
        longint lim  = i_full ? ((longint'(1) << w) - 1) : ((longint'(1) << sw) - 1);
        int     mpos = i_full ? w - 1 : sw - 1;
        bit     sat  = (s.c >= lim);
        bit     fin  = i_rd && (i_idx == last);
        bit     frz  = s.h || i_rd;
        bit     pe   = s.p || i_inc;
        longint nc;
        if (i_rd) s.d = int'(((s.c & lim) >> (8 * (last - i_idx))) & 255);
        if (fin) begin
            if (i_clr || sat) nc = pe ? 1 : 0;
            else nc = s.c + (pe ? 1 : 0);
            s.h = 1'b0;
            s.p = 1'b0;
        end else begin
            nc  = (i_inc && !frz && !sat) ? s.c + 1 : s.c;
            s.p = s.p || (frz && i_inc);
            s.h = s.h || i_rd;
        end
        s.a = !topbit(s.c, mpos) && topbit(nc, mpos);
        s.c = nc;
    endfunction

    task automatic check(input string req, input string what, input longint act, input longint exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    // One cycle: drive at the falling edge, update models, compare after the rise.
    task automatic tick(input bit t_inc, input bit t_rd, input int t_idx, input string req);
        @(negedge clk);
        inc = t_inc;
        rd  = t_rd;
        idx = 2'(t_idx);
        mstep(mb, t_inc, t_rd, t_idx, full, clr, 32, 16);
        mstep(ms, t_inc, t_rd, t_idx % 2, full, clr, 16, 8);
        @(posedge clk);
        #1;
        check(req, "big data", longint'(d_big), longint'(mb.d));
        check(req, "big attn", longint'(a_big), longint'(mb.a));
        check(req, "small data", longint'(d_small), longint'(ms.d));
        check(req, "small attn", longint'(a_small), longint'(ms.a));
    endtask

    task automatic read_all(input string req);
        for (int k = 0; k < 4; k++) tick(1'b0, 1'b1, k, req);
    endtask

    initial begin
        #(8 * 190000);
        errors++;
        $display("FAIL watchdog actual=running expected=finished");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        int seed;
        int attn_seen;
        seed = int'($urandom(32'd20240611));
        mb = '{c: 0, h: 0, p: 0, d: 0, a: 0};
        ms = '{c: 0, h: 0, p: 0, d: 0, a: 0};
        // R1: outputs under reset
        inc = 1'b1;
        repeat (3) @(posedge clk);
        #1;
        check("R1", "data in reset", longint'(d_big), 0);
        check("R1", "attn in reset", longint'(a_big), 0);
        @(negedge clk);
        inc = 1'b0;
        rst_n = 1'b1;
        read_all("R1");

        // R2/R3: plain counting then a big-endian read of 0x0000012C
        for (int k = 0; k < 300; k++) tick(1'b1, 1'b0, 0, "R2");
        tick(1'b0, 1'b1, 2, "R3");
        check("R3", "byte 2 of 0x12C", longint'(d_big), 64'h01);
        tick(1'b0, 1'b1, 3, "R3");
        check("R3", "byte 3 of 0x12C", longint'(d_big), 64'h2C);

        // R5/R11/R7: freeze with increments, repeat index 0, keep-value bump
        tick(1'b1, 1'b1, 0, "R11");
        for (int k = 0; k < 5; k++) tick(1'b1, 1'b0, 0, "R5");
        tick(1'b0, 1'b1, 0, "R5");
        tick(1'b1, 1'b1, 1, "R5");
        tick(1'b0, 1'b1, 2, "R5");
        check("R5", "frozen byte 2", longint'(d_big), 64'h01);
        tick(1'b0, 1'b1, 3, "R7");
        check("R7", "frozen byte 3", longint'(d_big), 64'h2C);
        read_all("R7");
        check("R7", "kept plus one", longint'(d_big), 64'h2D);
        read_all("R7");
        check("R7", "kept without pending", longint'(d_big), 64'h2D);

        // R6/R11: clear-on-read, increment on the completing cycle gives one
        clr = 1'b1;
        tick(1'b0, 1'b1, 0, "R6");
        tick(1'b0, 1'b1, 3, "R6");
        read_all("R6");
        check("R6", "cleared to zero", longint'(d_big), 0);
        tick(1'b0, 1'b1, 1, "R11");
        tick(1'b1, 1'b1, 3, "R11");
        read_all("R6");
        check("R6", "preset to one", longint'(d_big), 1);

        // R4/R8/R10/R9: narrow mode, run past the limit in keep-value mode
        clr = 1'b0;
        full = 1'b0;
        read_all("R4");
        attn_seen = 0;
        for (int k = 0; k < 65545; k++) begin
            tick(1'b1, 1'b0, 0, "R10");
            if (a_big) attn_seen++;
        end
        check("R10", "narrow attention pulses", longint'(attn_seen), 1);
        tick(1'b0, 1'b1, 0, "R4");
        check("R4", "upper index reads zero", longint'(d_big), 0);
        tick(1'b1, 1'b1, 2, "R8");
        check("R8", "saturated upper byte", longint'(d_big), 64'hFF);
        tick(1'b0, 1'b1, 3, "R9");
        check("R9", "saturated lower byte", longint'(d_big), 64'hFF);
        read_all("R9");
        check("R9", "recovered to one", longint'(d_big), 1);
        read_all("R9");
        check("R9", "kept after recovery", longint'(d_big), 1);

        // R2: constrained random mix of strobes, indices and modes
        for (int k = 0; k < 20000; k++) begin
            if ($urandom % 300 == 0) full = ~full;
            if ($urandom % 300 == 0) clr = ~clr;
            tick(bit'($urandom % 2), ($urandom % 4) == 0, int'($urandom % 4), "R2");
        end

        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule